// File: doc/BRIEF.md
# Multichannel FIR Filter with Per-Channel History Restore

This block runs a 32-tap FIR filter over packets of 16-bit signed samples. The packets come from many time-multiplexed channels, and each packet carries a 6-bit channel number. Each channel is filtered as though its packets were one unbroken stream.

When a packet ends, the 32 most recent input samples of that channel are written to a history memory. When a later packet of the same channel starts, that history is put back into the tap line before the first new sample is filtered.

Two engines take packets in turn. Each engine has its own delay line and controller. While one engine writes back the history of the packet it just finished, the other engine loads the history for the next packet and then filters it. A single multiplier bank serves whichever engine is filtering.

Both stream interfaces use valid/ready. A beat moves when valid and ready are high at the same clock edge. The input ready signal depends on the output ready signal through combinational logic, so the source must not wait for ready before it raises valid. Once the output presents a beat, it holds that beat unchanged until the sink accepts it.

Top module: `mcfir_top`

## Requirements
- R1: Each accepted sample x[n] produces y[n] = sum over k=0..31 of c[k]*x[n-k]. The coefficients are c[k] = 200*(k+1) for k < 16 and c[k] = 200*(32-k) for k >= 16. The full-precision sum is shifted arithmetically right by 15, and its low 16 bits form the output.
- R2: For the first packet of a channel after reset, every earlier sample of that channel is taken as zero.
- R3: Packets of different channels may be interleaved in any order. Each channel's output equals filtering that channel's samples as one continuous sequence.
- R4: Two consecutive packets may belong to the same channel. The second continues from the last 32 samples of the first, and it is accepted one cycle after its first beat is presented.
- R5: Every accepted input beat yields exactly one output beat on the next cycle. The output carries the same channel number, and it carries the last marker exactly when the input beat did.
- R6: While m_valid is high and m_ready is low, m_valid, m_data, m_chan and m_last hold their values. Input is accepted only when the output register is empty or is being read in the same cycle.
- R7: Loading history from the memory produces no output beat. The input is held off for exactly 34 cycles after the first beat of such a packet is presented to an idle engine.
- R8: The engines alternate packet by packet. After a packet ends, a next packet of a channel not yet seen is accepted after one cycle, while the first engine's 32-cycle write-back continues. At most one engine filters at a time, and at most one writes the memory.
- R9: After reset, m_valid and s_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with s_valid |
| s_data | input | 16 | Input sample, signed |
| s_chan | input | 6 | Channel number of the input packet |
| s_last | input | 1 | Marks the final beat of an input packet |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Sink accepts the output beat |
| m_data | output | 16 | Filtered sample, signed |
| m_chan | output | 6 | Channel number of the output beat |
| m_last | output | 1 | Marks the final beat of an output packet |

## Verification
The same packet table is streamed twice: once with the sink always ready, and once with pseudo-random stalls. The table mixes packet lengths of one beat, of exactly the tap count and of more than the tap count. It also interleaves channels and places same-channel packets back to back. A continuous per-channel reference model therefore separates correct history restore from two failure modes: restarting from zero, and taking the wrong channel's history.

Directed packets on channels not used before check three cases of the time it takes before input is accepted. A new channel is accepted after one cycle. A channel whose history must come from the memory is accepted after 34 cycles. A back-to-back packet of the same channel is accepted after one cycle, because its history is taken over from the other engine. An impulse packet shows the coefficient shape and the output scaling.

// File: rtl/mcfir_pkg.sv
package mcfir_pkg;

  // Engine control states
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_LOAD = 2'd1,
    ENG_FILT = 2'd2,
    ENG_SAVE = 2'd3
  } eng_st_e;

  // Fixed coefficient shape: a triangle peaking in the middle of the tap line
  function automatic int coef_at(int k, int taps);
    return (k < taps / 2) ? 200 * (k + 1) : 200 * (taps - k);
  endfunction

endpackage

// File: rtl/mcfir_hist_mem.sv
module mcfir_hist_mem #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mcfir_engine.sv
module mcfir_engine
  import mcfir_pkg::*;
#(
  parameter int TAPS = 32,
  parameter int DW   = 16,
  parameter int CHW  = 6,
  localparam int IW   = $clog2(TAPS),
  localparam int CNTW = IW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  // packet start request from the top
  input  logic                      start,
  input  logic [CHW-1:0]            start_chan,
  input  logic                      start_zero,
  input  logic                      start_fwd,
  input  logic [TAPS-1:0][DW-1:0]   fwd_line,
  // history memory read data (one cycle after index)
  input  logic [DW-1:0]             rd_data,
  // sample stream
  input  logic                      fire,
  input  logic [DW-1:0]             din,
  input  logic                      last_in,
  // memory write grant
  input  logic                      grant,
  output eng_st_e                   st,
  output logic [CHW-1:0]            chan,
  output logic [TAPS-1:0][DW-1:0]   line,
  output logic [IW-1:0]             idx,
  output logic                      has_hist
);

  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(TAPS);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(TAPS - 1);

  logic [CNTW-1:0] cnt;

  assign idx = cnt[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ENG_IDLE;
      cnt      <= '0;
      chan     <= '0;
      has_hist <= 1'b0;
      line     <= '0;
    end else begin
      unique case (st)
        ENG_IDLE: begin
          if (start) begin
            chan <= start_chan;
            cnt  <= '0;
            if (start_fwd) begin
              line <= fwd_line;
              st   <= ENG_FILT;
            end else if (start_zero) begin
              line <= '0;
              st   <= ENG_FILT;
            end else begin
              st   <= ENG_LOAD;
            end
          end
        end
        ENG_LOAD: begin
          // read issued with idx = cnt, data lands one cycle later
          if (cnt != '0) line[idx - IW'(1)] <= rd_data;
          if (cnt == CNT_FULL) st <= ENG_FILT;
          else                 cnt <= cnt + CNTW'(1);
        end
        ENG_FILT: begin
          if (fire) begin
            line <= {line[TAPS-2:0], din};
            if (last_in) begin
              st       <= ENG_SAVE;
              cnt      <= '0;
              has_hist <= 1'b1;
            end
          end
        end
        ENG_SAVE: begin
          if (grant) begin
            if (cnt == CNT_LAST) st <= ENG_IDLE;
            cnt <= cnt + CNTW'(1);
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mcfir_mac.sv
module mcfir_mac
  import mcfir_pkg::*;
#(
  parameter int TAPS = 32,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int AW  = DW + CW + $clog2(TAPS)
) (
  input  logic [DW-1:0]           din,
  input  logic [TAPS-2:0][DW-1:0] hist,
  output logic [DW-1:0]           y
);

  logic signed [AW-1:0] prod [TAPS];
  logic signed [AW-1:0] acc;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic signed [CW-1:0] CK = CW'(coef_at(k, TAPS));
    logic signed [DW-1:0] xk;
    if (k == 0) begin : g_new
      assign xk = din;
    end else begin : g_old
      assign xk = hist[k-1];
    end
    assign prod[k] = xk * CK;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
  end

  // arithmetic shift by CW-1, keep DW bits
  assign y = acc[CW-1 +: DW];

endmodule

// File: rtl/mcfir_top.sv
module mcfir_top
  import mcfir_pkg::*;
#(
  parameter int TAPS = 32,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int CHW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [DW-1:0]  s_data,
  input  logic [CHW-1:0] s_chan,
  input  logic           s_last,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [DW-1:0]  m_data,
  output logic [CHW-1:0] m_chan,
  output logic           m_last
);

  localparam int NCH = 1 << CHW;
  localparam int IW  = $clog2(TAPS);
  localparam int MAW = CHW + IW;

  eng_st_e                 est   [2];
  logic [CHW-1:0]          echan [2];
  logic [TAPS-1:0][DW-1:0] eline [2];
  logic [IW-1:0]           eidx  [2];
  logic [1:0]              ehist;
  logic [1:0]              estart;
  logic [1:0]              efire;
  logic [1:0]              grant;
  logic [1:0]              eng_filt;
  logic [1:0]              eng_wr;

  logic           cur;
  logic           own;
  logic [NCH-1:0] seen;
  logic [DW-1:0]  rd_data;
  logic [DW-1:0]  y;
  logic           s_fire;
  logic           wsel;

  assign s_ready = (est[cur] == ENG_FILT) && (!m_valid || m_ready);
  assign s_fire  = s_valid && s_ready;

  for (genvar e = 0; e < 2; e++) begin : g_eng
    localparam int O = 1 - e;
    logic fwd_ok;
    assign fwd_ok = ehist[O] && (echan[O] == s_chan) &&
                    ((est[O] == ENG_SAVE) || (est[O] == ENG_IDLE));
    assign estart[e]   = (cur == 1'(e)) && s_valid && (est[e] == ENG_IDLE);
    assign efire[e]    = s_fire && (cur == 1'(e));
    assign grant[e]    = (est[e] == ENG_SAVE) && ((est[O] != ENG_SAVE) || (own == 1'(e)));
    assign eng_filt[e] = (est[e] == ENG_FILT);
    assign eng_wr[e]   = grant[e];

    mcfir_engine #(
      .TAPS (TAPS),
      .DW   (DW),
      .CHW  (CHW)
    ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (estart[e]),
      .start_chan (s_chan),
      .start_zero (!seen[s_chan]),
      .start_fwd  (fwd_ok),
      .fwd_line   (eline[O]),
      .rd_data    (rd_data),
      .fire       (efire[e]),
      .din        (s_data),
      .last_in    (s_last),
      .grant      (grant[e]),
      .st         (est[e]),
      .chan       (echan[e]),
      .line       (eline[e]),
      .idx        (eidx[e]),
      .has_hist   (ehist[e])
    );
  end

  // write-port ownership: the engine that entered write-back first keeps it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own <= 1'b0;
    end else if (est[0] == ENG_SAVE && est[1] != ENG_SAVE) begin
      own <= 1'b0;
    end else if (est[1] == ENG_SAVE && est[0] != ENG_SAVE) begin
      own <= 1'b1;
    end
  end

  // packet ping-pong and channel-seen tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= 1'b0;
      seen <= '0;
    end else if (s_fire && s_last) begin
      cur  <= ~cur;
      seen <= seen | (NCH'(1) << s_chan);
    end
  end

  assign wsel = grant[1];

  mcfir_hist_mem #(
    .DW (DW),
    .AW (MAW)
  ) u_mem (
    .clk   (clk),
    .we    (|grant),
    .waddr ({echan[wsel], eidx[wsel]}),
    .wdata (eline[wsel][eidx[wsel]]),
    .raddr ({echan[cur], eidx[cur]}),
    .rdata (rd_data)
  );

  mcfir_mac #(
    .TAPS (TAPS),
    .DW   (DW),
    .CW   (CW)
  ) u_mac (
    .din  (s_data),
    .hist (eline[cur][TAPS-2:0]),
    .y    (y)
  );

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_chan  <= '0;
      m_last  <= 1'b0;
    end else if (s_fire) begin
      m_valid <= 1'b1;
      m_data  <= y;
      m_chan  <= s_chan;
      m_last  <= s_last;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mcfir_chk.sv
module mcfir_chk #(
  parameter int DW  = 16,
  parameter int CHW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           s_ready,
  input logic [CHW-1:0] s_chan,
  input logic           s_last,
  input logic           m_valid,
  input logic           m_ready,
  input logic [DW-1:0]  m_data,
  input logic [CHW-1:0] m_chan,
  input logic           m_last,
  input logic [1:0]     eng_filt,
  input logic [1:0]     eng_wr
);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_chan) && $stable(m_last));

  // R5
  beat_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid && m_chan == $past(s_chan) && m_last == $past(s_last));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) && (!m_valid || m_ready) |=> !m_valid);

  // R8
  one_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_filt));

  // R8
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_wr));

endmodule

bind mcfir_top mcfir_chk #(.DW(DW), .CHW(CHW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_chan   (s_chan),
  .s_last   (s_last),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .m_chan   (m_chan),
  .m_last   (m_last),
  .eng_filt (eng_filt),
  .eng_wr   (eng_wr)
);

// File: tb/mcfir_top_tb.sv
module mcfir_top_tb;

  localparam int TAPS = 32;
  localparam int NB   = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic [5:0]  s_chan = '0;
  logic        s_last = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_data;
  logic [5:0]  m_chan;
  logic        m_last;

  always #5 clk = ~clk;

  mcfir_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_chan(s_chan), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan), .m_last(m_last)
  );

  // packet table: chan*256 + length
  localparam int unsigned PK_TAB [12] = '{
    0*256+5,  1*256+3,  0*256+7,   2*256+40, 63*256+1, 2*256+2,
    2*256+33, 1*256+32, 5*256+1,   5*256+1,  0*256+12, 63*256+20
  };

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gidx = 0;
  logic [15:0] lfsr = 16'hACE1;

  // beat list
  logic [15:0] b_data [NB];
  logic [5:0]  b_chan [NB];
  logic        b_last [NB];
  logic        b_first[NB];
  int          b_pkt  [NB];
  int          nbeats = 0;
  int          npk = 0;
  int          lat [64];

  // expected outputs
  logic [15:0] e_data [NB];
  logic [5:0]  e_chan [NB];
  logic        e_last [NB];

  // reference history, newest at index 0
  int hist [64][TAPS];

  function automatic int coef(int k);
    return (k < 16) ? 200 * (k + 1) : 200 * (32 - k);
  endfunction

  function automatic logic [15:0] gen(int g);
    logic [31:0] h;
    h = 32'(g) * 32'd1103515245 + 32'd12345;
    return {{3{h[30]}}, h[30:18]};
  endfunction

  function automatic logic [15:0] model_step(int ch, logic [15:0] x);
    longint acc;
    for (int k = TAPS - 1; k > 0; k--) hist[ch][k] = hist[ch][k-1];
    hist[ch][0] = int'($signed(x));
    acc = 0;
    for (int k = 0; k < TAPS; k++) acc += longint'(coef(k)) * longint'(hist[ch][k]);
    return 16'(acc >>> 15);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_beats();
    nbeats = 0;
    npk = 0;
    for (int i = 0; i < 64; i++) lat[i] = 0;
  endtask

  // kind 0: generated samples, kind 1: impulse of 16384 then zeros
  task automatic add_pkt(input int ch, input int len, input int kind);
    for (int i = 0; i < len; i++) begin
      if (kind == 1) b_data[nbeats] = (i == 0) ? 16'd16384 : 16'd0;
      else begin
        b_data[nbeats] = gen(gidx);
        gidx++;
      end
      b_chan[nbeats]  = 6'(ch);
      b_last[nbeats]  = (i == len - 1);
      b_first[nbeats] = (i == 0);
      b_pkt[nbeats]   = npk;
      nbeats++;
    end
    npk++;
  endtask

  // stream the beat list; mode 0: sink always ready, mode 1: random stalls
  task automatic run_stream(input int mode);
    int bi;
    int rd;
    int wr;
    bit fired;
    bit stall_prev;
    logic [15:0] pd;
    logic [5:0]  pc;
    logic        pl;
    bi = 0; rd = 0; wr = 0; fired = 0; stall_prev = 0;
    pd = '0; pc = '0; pl = 1'b0;
    while (1) begin
      @(negedge clk);
      if (fired) bi++;
      if (bi < nbeats) begin
        s_valid = 1'b1;
        s_data  = b_data[bi];
        s_chan  = b_chan[bi];
        s_last  = b_last[bi];
      end else begin
        s_valid = 1'b0;
        s_last  = 1'b0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      #1;
      if (stall_prev) begin
        chk(m_valid && m_data == pd && m_chan == pc && m_last == pl,
            "R6", "held output", longint'(m_data), longint'(pd));
      end
      stall_prev = m_valid && !m_ready;
      pd = m_data; pc = m_chan; pl = m_last;
      if (m_valid && m_ready) begin
        if (rd < wr) begin
          chk(m_data == e_data[rd], "R1 R2 R3 R4", "data",
              longint'($signed(m_data)), longint'($signed(e_data[rd])));
          chk(m_chan == e_chan[rd], "R5", "chan", longint'(m_chan), longint'(e_chan[rd]));
          chk(m_last == e_last[rd], "R5", "last", longint'(m_last), longint'(e_last[rd]));
        end else begin
          chk(1'b0, "R5", "extra output beat", longint'(rd), longint'(wr));
        end
        rd++;
      end
      fired = s_valid && s_ready;
      if (fired) begin
        e_data[wr] = model_step(int'(b_chan[bi]), b_data[bi]);
        e_chan[wr] = b_chan[bi];
        e_last[wr] = b_last[bi];
        wr++;
      end else if (s_valid && b_first[bi]) begin
        lat[b_pkt[bi]]++;
      end
      if (bi >= nbeats && rd >= wr && !m_valid) break;
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
    chk(rd == nbeats, "R5", "output beat count", longint'(rd), longint'(nbeats));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 64; c++)
      for (int k = 0; k < TAPS; k++) hist[c][k] = 0;

    // reset state (R9)
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R9", "m_valid after reset", longint'(m_valid), 0);
    chk(s_ready == 1'b0, "R9", "s_ready after reset", longint'(s_ready), 0);

    // table walk: two passes, second with sink stalls (R3 R6)
    for (int pass = 0; pass < 2; pass++) begin
      clear_beats();
      for (int p = 0; p < 12; p++) add_pkt(int'(PK_TAB[p] >> 8), int'(PK_TAB[p] & 255), 0);
      run_stream(pass);
      idle(60);
    end

    // directed: new channel, then another new channel back to back (R2 R8)
    clear_beats();
    add_pkt(40, 4, 0);
    add_pkt(41, 3, 0);
    run_stream(0);
    chk(lat[0] == 1, "R2", "new channel start wait", longint'(lat[0]), 1);
    chk(lat[1] == 1, "R8", "next packet during write-back wait", longint'(lat[1]), 1);
    idle(60);

    // directed: history from memory, then same channel back to back (R7 R4)
    clear_beats();
    add_pkt(40, 6, 0);
    add_pkt(40, 5, 0);
    run_stream(0);
    chk(lat[0] == 34, "R7", "history load wait", longint'(lat[0]), 34);
    chk(lat[1] == 1, "R4", "same channel handover wait", longint'(lat[1]), 1);
    idle(60);

    // directed: impulse shows coefficient shape and scaling (R1)
    clear_beats();
    add_pkt(50, 34, 1);
    run_stream(0);
    chk(e_data[0] == 16'd100, "R1", "impulse tap 0", longint'(e_data[0]), 100);
    chk(e_data[15] == 16'd1600, "R1", "impulse tap 15", longint'(e_data[15]), 1600);
    chk(e_data[31] == 16'd100, "R1", "impulse tap 31", longint'(e_data[31]), 100);
    chk(e_data[32] == 16'd0, "R1", "impulse past tap line", longint'(e_data[32]), 0);

    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule